// File: doc/BRIEF.md
# Atomic Set/Clear GPIO Port

This block is a memory-mapped general-purpose I/O port of up to 32 lines behind a plain 32-bit register bus. The bus has a byte address, a write enable with write data, and a read enable with read data. Software never overwrites the output level, direction or debounce-enable state of a line with a plain store. Each of these three per-line vectors has one address where written ones set bits and a second address where written ones clear bits. This lets separate software agents change single lines without a read-modify-write race.

The current direction vector can be read back at its own status address. A further address returns the pad input levels after a two-flop synchronizer. Each pin's output enable follows its direction bit, and the output value follows its data bit only while the line is an output. The debounce-enable vector is presented on a port for the pad-side filter. The number of implemented lines is a parameter. Lines above that count are absent: they read as zero and ignore writes.

Top module: `gpio_setclr_port`

## Requirements
- R1: A write to byte address 0x000 sets every output-data bit whose write-data bit is 1; bits written as 0 keep their value.
- R2: A write to byte address 0x004 clears every output-data bit whose write-data bit is 1; bits written as 0 keep their value.
- R3: Writes to 0x010 set, and writes to 0x014 clear, direction bits in the same way (1 = output); a read of 0x018 returns the direction vector.
- R4: A read of 0x080 returns the pad input levels after a two-flop synchronizer: a pad change made in the same cycle as the read request appears in the third back-to-back read, and not in the first two.
- R5: Writes to 0x060 set, and writes to 0x064 clear, per-line debounce-enable bits, which appear on `dbnc_en`.
- R6: Lines at index NUM_LINES and above read as 0 at every address, ignore every write, and drive 0 on `pad_oe`, `pad_out` and `dbnc_en`.
- R7: `pad_oe` equals the direction vector; `pad_out` carries a line's data bit only while its direction bit is 1, and is 0 otherwise.
- R8: Synchronous active-high reset clears data, direction and debounce enables to 0, so every line starts as an input.
- R9: Read data is registered and appears in the cycle after the read request. It is 0 in any cycle that follows no read. It is also 0 for reads of the set-only and clear-only addresses, of unmapped addresses, and of addresses whose two low bits are not zero; a write to any such unmapped address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data, one bit per line |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| dbnc_en | output | 32 | Per-line debounce enables |

## Verification
The assertions assume a single access per cycle: write and read strobes are never both high, and the address is stable only in the cycle it is used. They also assume `pad_in` is sampled through the synchronizer, so nothing is claimed about its value before two clocks have passed. The stimulus issues one write or one read per cycle from the falling edge and never asserts both strobes together. It uses a port of fewer than 32 lines so that the absent upper lines are exercised.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int BUS_W     = 32;
    localparam int MAX_LINES = 32;
    localparam int ADDR_W    = 8;
    localparam int WIDX_W    = ADDR_W - 2;

    // Word index of each mapped register (byte address divided by four)
    typedef enum logic [WIDX_W-1:0] {
        WI_DATA_SET = 6'h00,
        WI_DATA_CLR = 6'h01,
        WI_DIR_SET  = 6'h04,
        WI_DIR_CLR  = 6'h05,
        WI_DIR_STAT = 6'h06,
        WI_DBN_SET  = 6'h18,
        WI_DBN_CLR  = 6'h19,
        WI_PIN_LVL  = 6'h20
    } word_idx_e;

    typedef struct packed {
        logic data_set;
        logic data_clr;
        logic dir_set;
        logic dir_clr;
        logic dbn_set;
        logic dbn_clr;
    } wr_strobes_t;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_DIR,
        RSEL_PIN
    } rd_sel_e;

    function automatic logic [BUS_W-1:0] line_mask(input int n);
        logic [BUS_W-1:0] m;
        for (int i = 0; i < BUS_W; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

    function automatic logic addr_aligned(input logic [ADDR_W-1:0] a);
        return (a[1:0] == 2'b00);
    endfunction

    function automatic wr_strobes_t decode_write(input logic we,
                                                 input logic [ADDR_W-1:0] a);
        wr_strobes_t s;
        logic [WIDX_W-1:0] w;
        s = '0;
        w = a[ADDR_W-1:2];
        if (we && addr_aligned(a)) begin
            case (w)
                WI_DATA_SET: s.data_set = 1'b1;
                WI_DATA_CLR: s.data_clr = 1'b1;
                WI_DIR_SET:  s.dir_set  = 1'b1;
                WI_DIR_CLR:  s.dir_clr  = 1'b1;
                WI_DBN_SET:  s.dbn_set  = 1'b1;
                WI_DBN_CLR:  s.dbn_clr  = 1'b1;
                default:     s = '0;
            endcase
        end
        return s;
    endfunction

    function automatic rd_sel_e decode_read(input logic [ADDR_W-1:0] a);
        rd_sel_e r;
        r = RSEL_NONE;
        if (addr_aligned(a)) begin
            case (a[ADDR_W-1:2])
                WI_DIR_STAT: r = RSEL_DIR;
                WI_PIN_LVL:  r = RSEL_PIN;
                default:     r = RSEL_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
    parameter int W     = 32,
    parameter int LIVE  = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < LIVE) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bit_q <= 1'b0;
                end else if (set_en && bits[i]) begin
                    bit_q <= 1'b1;
                end else if (clr_en && bits[i]) begin
                    bit_q <= 1'b0;
                end
            end
            assign q[i] = bit_q;
        end else begin : g_absent
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  dir_vec,
    input  logic [BUS_W-1:0]  pin_vec,
    output logic [BUS_W-1:0]  rdata
);
    localparam logic [BUS_W-1:0] LMASK = line_mask(NUM_LINES);

    rd_sel_e          sel;
    logic [BUS_W-1:0] rd_next;

    always_comb begin
        sel = decode_read(addr);
        case (sel)
            RSEL_DIR: rd_next = dir_vec & LMASK;
            RSEL_PIN: rd_next = pin_vec & LMASK;
            default:  rd_next = '0;
        endcase
        if (!re) begin
            rd_next = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= rd_next;
        end
    end
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
    import gpio_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_re,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [BUS_W-1:0]  pad_in,
    output logic [BUS_W-1:0]  pad_out,
    output logic [BUS_W-1:0]  pad_oe,
    output logic [BUS_W-1:0]  dbnc_en
);
    localparam int LIVE = (NUM_LINES > MAX_LINES) ? MAX_LINES :
                          (NUM_LINES < 1) ? 1 : NUM_LINES;

    wr_strobes_t      wstb;
    logic [BUS_W-1:0] data_q;
    logic [BUS_W-1:0] dir_q;
    logic [BUS_W-1:0] dbn_q;
    logic [BUS_W-1:0] pin_sync;

    assign wstb = decode_write(bus_we, bus_addr);

    gpio_setclr_reg #(.W(BUS_W), .LIVE(LIVE)) u_data (
        .clk(clk), .rst(rst),
        .set_en(wstb.data_set), .clr_en(wstb.data_clr),
        .bits(bus_wdata), .q(data_q)
    );

    gpio_setclr_reg #(.W(BUS_W), .LIVE(LIVE)) u_dir (
        .clk(clk), .rst(rst),
        .set_en(wstb.dir_set), .clr_en(wstb.dir_clr),
        .bits(bus_wdata), .q(dir_q)
    );

    gpio_setclr_reg #(.W(BUS_W), .LIVE(LIVE)) u_dbn (
        .clk(clk), .rst(rst),
        .set_en(wstb.dbn_set), .clr_en(wstb.dbn_clr),
        .bits(bus_wdata), .q(dbn_q)
    );

    gpio_sync2 #(.W(BUS_W)) u_sync (
        .clk(clk), .rst(rst),
        .async_in(pad_in), .sync_out(pin_sync)
    );

    gpio_read_mux #(.NUM_LINES(LIVE)) u_rd (
        .clk(clk), .rst(rst),
        .re(bus_re), .addr(bus_addr),
        .dir_vec(dir_q), .pin_vec(pin_sync),
        .rdata(bus_rdata)
    );

    assign pad_oe  = dir_q;
    assign pad_out = data_q & dir_q;
    assign dbnc_en = dbn_q;
endmodule

// File: rtl/gpio_setclr_chk.sv
module gpio_setclr_chk
    import gpio_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              bus_re,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [BUS_W-1:0]  pad_out,
    input logic [BUS_W-1:0]  pad_oe,
    input logic [BUS_W-1:0]  dbnc_en,
    input logic [BUS_W-1:0]  data_q
);
    localparam logic [BUS_W-1:0] LMASK = line_mask(NUM_LINES);

    AST_DATA_SET: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'h00) |=>
        ((data_q & $past(bus_wdata) & LMASK) == ($past(bus_wdata) & LMASK))); // R1

    AST_DATA_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'h04) |=> ((data_q & $past(bus_wdata)) == '0)); // R2

    AST_DATA_KEEP: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'h00) |=>
        ((data_q & ~$past(bus_wdata)) == ($past(data_q) & ~$past(bus_wdata)))); // R1

    AST_DIR_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'h14) |=> ((pad_oe & $past(bus_wdata)) == '0)); // R3

    AST_DBN_SET: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'h60) |=>
        ((dbnc_en & $past(bus_wdata) & LMASK) == ($past(bus_wdata) & LMASK))); // R5

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe | pad_out | dbnc_en | bus_rdata) & ~LMASK) == '0); // R6

    AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && data_q == '0 && dbnc_en == '0)); // R8

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> (bus_rdata == '0)); // R9
endmodule

bind gpio_setclr_port gpio_setclr_chk #(.NUM_LINES(NUM_LINES)) u_setclr_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_out(pad_out), .pad_oe(pad_oe), .dbnc_en(dbnc_en), .data_q(data_q)
);

// File: tb/test_gpio_setclr_port.sv
module test_gpio_setclr_port;
    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 20;
    localparam int NVEC       = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [31:0] dbnc_en;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_setclr_port #(.NUM_LINES(LINES)) i_gpio_setclr_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .dbnc_en(dbnc_en)
    );

    // {addr, wdata, expected pad_oe, expected pad_out}, 20 live lines
    localparam logic [103:0] VEC [NVEC] = '{
        {8'h10, 32'hFFFF_FFFF, 32'h000F_FFFF, 32'h0000_0000}, // R3 all outputs, R6 upper dropped
        {8'h00, 32'h0000_F0F0, 32'h000F_FFFF, 32'h0000_F0F0}, // R1
        {8'h00, 32'h00F0_0003, 32'h000F_FFFF, 32'h0000_F0F3}, // R1 R6
        {8'h04, 32'h0000_00F1, 32'h000F_FFFF, 32'h0000_F002}, // R2
        {8'h14, 32'h0000_F000, 32'h000F_0FFF, 32'h0000_0002}, // R3 R7
        {8'h60, 32'hFFFF_FFFF, 32'h000F_0FFF, 32'h0000_0002}, // R5
        {8'h04, 32'hFFFF_FFFF, 32'h000F_0FFF, 32'h0000_0000}, // R2
        {8'h20, 32'h0000_FFFF, 32'h000F_0FFF, 32'h0000_0000}  // R9 unmapped write
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_re = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        check("R8 pad_oe", pad_oe, 32'h0);
        check("R8 pad_out", pad_out, 32'h0);
        check("R8 dbnc_en", dbnc_en, 32'h0);
        rd(8'h18, rv);
        check("R8 dir readback", rv, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][103:96], VEC[i][95:64]);
            check("R1 R2 R3 pad_oe vector", pad_oe, VEC[i][63:32]);
            check("R7 pad_out vector", pad_out, VEC[i][31:0]);
        end

        // R5 debounce enables after set of all ones, then a partial clear
        check("R5 dbnc set", dbnc_en, 32'h000F_FFFF);
        wr(8'h64, 32'h0000_000F);
        check("R5 dbnc clear", dbnc_en, 32'h000F_FFF0);

        // R3 direction status
        rd(8'h18, rv);
        check("R3 dir status", rv, 32'h000F_0FFF);
        // R9 idle cycle returns 0
        @(negedge clk);
        check("R9 idle rdata", bus_rdata, 32'h0);
        // R9 reads of set/clear, unmapped and misaligned addresses
        rd(8'h10, rv);
        check("R9 read set addr", rv, 32'h0);
        rd(8'h64, rv);
        check("R9 read clear addr", rv, 32'h0);
        rd(8'h24, rv);
        check("R9 read unmapped", rv, 32'h0);
        rd(8'h1A, rv);
        check("R9 read misaligned", rv, 32'h0);
        wr(8'h02, 32'hFFFF_FFFF);
        check("R9 misaligned write ignored", pad_out, 32'h0);

        // R4 synchronizer latency: change pad with the first of three reads
        pad_in = 32'hA5A5_A5A5;
        repeat (3) @(negedge clk);
        rd(8'h80, rv);
        check("R4 pad level", rv, 32'h0005_A5A5);
        pad_in = 32'hFFF1_2345;
        rd(8'h80, rv);
        check("R4 first read old", rv, 32'h0005_A5A5);
        rd(8'h80, rv);
        check("R4 second read old", rv, 32'h0005_A5A5);
        rd(8'h80, rv);
        check("R4 third read new R6 masked", rv, 32'h0001_2345);

        // R7 direction gates drive: data set, line switched to input
        wr(8'h00, 32'h0000_0101);
        check("R7 driven", pad_out, 32'h0000_0101);
        wr(8'h14, 32'h0000_0001);
        check("R7 input not driven", pad_out, 32'h0000_0100);
        wr(8'h10, 32'h0000_0001);
        check("R7 data kept while input", pad_out, 32'h0000_0101);

        // R8 reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 rerun oe", pad_oe, 32'h0);
        check("R8 rerun dbnc", dbnc_en, 32'h0);
        wr(8'h10, 32'h0000_0001);
        check("R8 data cleared", pad_out, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule